// File: doc/BRIEF.md
# Video Input Timing Detector

This block watches a parallel video stream in its own pixel-clock domain and works out the stream's timing from the sync and data-enable lines alone. It reports whether the link is locked and whether a live stream is present. It also classifies the polarity of each sync line as active low, active high or absent. Its measurements are the active width and height, the sync pulse widths, and the horizontal and vertical porches.

Every sync line passes through a polarity classifier. The classifier decides which level is the asserted one from the duty cycle and produces a normalised, active-high copy of that sync. Horizontal and vertical measurement units then time the normalised syncs against DE. The top level copies their results into the output registers once per frame, at the asserting edge of vertical sync. Those registers hold steady for the rest of the frame and fall to zero as soon as the stream goes away.

Top module: `vid_timing_detect`

## Requirements
- R1: `link_up` follows `lock_in` with one register stage, whatever the state of the stream. When the lock is lost, `stream_up` is 0.
- R2: `stream_up` is 1 only when three conditions hold: the registered lock is high, the registered `pclk_ok_in` is high, and DE has changed level within the last `TMO` pixel clocks. In every other case it is 0.
- R3: `hs_pol` and `vs_pol` use the code 0 for active low, 1 for active high and 2 for absent. The value 3 never appears. A sync whose low phase is shorter than its high phase is reported as active low. A sync whose high phase is the shorter one is reported as active high.
- R4: A sync line that shows no edge for `TMO` pixel clocks is reported with code 2, while the other sync keeps its own code.
- R5: `hs_width` is the number of pixel clocks for which the normalised HSYNC is asserted. `hs_bporch` counts the pixel clocks from HSYNC deassertion to the first DE=1 pixel. `hs_fporch` counts the pixel clocks from the last DE=1 pixel to the next HSYNC assertion.
- R6: `act_width` is the number of DE=1 pixels on a line. `act_height` is the number of lines in a frame that contain DE=1.
- R7: `vs_lines` is the number of HSYNC assertions counted while VSYNC is asserted, including the one that coincides with the VSYNC assertion. `vs_bporch` is the number of lines from VSYNC deassertion to the first active line. `vs_fporch` is the number of HSYNC assertions from the last active line up to, but not including, the VSYNC assertion.
- R8: The measurement outputs change only at a VSYNC assertion that is preceded by at least one complete frame with the stream present. Before that they stay at zero, and between two such edges they are held unchanged.
- R9: All measurement outputs are zero in the clock cycle after any cycle in which `stream_up` is 0, and they are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_in | input | 1 | Raw horizontal sync, either polarity |
| vsync_in | input | 1 | Raw vertical sync, either polarity |
| de_in | input | 1 | Data enable, high on active pixels |
| lock_in | input | 1 | Deserializer link-lock flag |
| pclk_ok_in | input | 1 | Pixel clock running indication |
| link_up | output | 1 | Registered link status |
| stream_up | output | 1 | Stream present |
| hs_pol | output | 2 | HSYNC polarity code (0 low, 1 high, 2 absent) |
| vs_pol | output | 2 | VSYNC polarity code (0 low, 1 high, 2 absent) |
| act_width | output | HW | Active pixels per line |
| act_height | output | VW | Active lines per frame |
| hs_width | output | HW | HSYNC pulse width in pixel clocks |
| hs_bporch | output | HW | Horizontal back porch in pixel clocks |
| hs_fporch | output | HW | Horizontal front porch in pixel clocks |
| vs_lines | output | VW | VSYNC pulse width in lines |
| vs_bporch | output | VW | Vertical back porch in lines |
| vs_fporch | output | VW | Vertical front porch in lines |

## Verification
`link_up` and `stream_up` respond one clock after the input changes, and the checks for them sample at the falling edge that follows. The one exception is loss of DE activity: `stream_up` falls only after `TMO` quiet clocks, so the bench leaves it three whole frames before looking. Measurements appear only on the second VSYNC assertion after the stream comes up. The bench therefore raises the lock partway through a frame, confirms that the outputs are still zero at the ends of the next two frames, and reads the values early in the third frame and again at its last pixel to catch any change inside the frame. A polarity code settles once the sync has completed both of its phases, and three settling frames pass before each configuration is measured.

// File: rtl/vtd_pkg.sv
// Shared definitions for the video timing detector.
package vtd_pkg;

    // Sync polarity classification; code values are visible at the ports.
    typedef enum logic [1:0] {
        POL_LOW  = 2'd0,
        POL_HIGH = 2'd1,
        POL_NONE = 2'd2
    } pol_e;

endpackage

// File: rtl/vtd_sync_class.sv
// Sync polarity classifier.
// Measures the lengths of the high and low phases of one raw sync line. The
// shorter phase is taken as the asserted level. Outputs the polarity code and
// a normalised copy of the sync that is high while it is asserted.
// Assumes: raw is already registered in the pixel-clock domain. A phase
// length is only trusted when both of its ends were observed edges. No edge
// for TMO clocks means the sync is absent.
module vtd_sync_class
    import vtd_pkg::*;
#(
    parameter int TMO = 1 << 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output pol_e code,
    output logic act
);
    localparam int IW = $clog2(TMO + 1);
    localparam logic [IW-1:0] TMO_V = IW'(TMO);

    logic          raw_q;
    logic [IW-1:0] run;
    logic [IW-1:0] hi_len, lo_len;
    logic          seen, hi_ok, lo_ok;
    logic          edge_w;
    logic          idle_w;

    assign edge_w = raw ^ raw_q;
    assign idle_w = (run >= TMO_V);

    // Phase length capture and timeout of the sync line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= 1'b0;
            run    <= '0;
            hi_len <= '0;
            lo_len <= '0;
            seen   <= 1'b0;
            hi_ok  <= 1'b0;
            lo_ok  <= 1'b0;
        end else begin
            raw_q <= raw;
            if (edge_w) begin
                run  <= IW'(1);
                seen <= 1'b1;
                if (seen) begin
                    if (raw) begin
                        lo_len <= run;
                        lo_ok  <= 1'b1;
                    end else begin
                        hi_len <= run;
                        hi_ok  <= 1'b1;
                    end
                end
            end else if (!idle_w) begin
                run <= run + IW'(1);
            end else begin
                seen  <= 1'b0;
                hi_ok <= 1'b0;
                lo_ok <= 1'b0;
            end
        end
    end

    // Polarity decision from the two captured phase lengths
    always_comb begin
        if (!hi_ok || !lo_ok || idle_w) code = POL_NONE;
        else if (hi_len < lo_len)       code = POL_HIGH;
        else                            code = POL_LOW;
    end

    // Normalised asserted level; never asserted when absent
    always_comb begin
        case (code)
            POL_HIGH: act = raw;
            POL_LOW:  act = ~raw;
            default:  act = 1'b0;
        endcase
    end

    // R3
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code != 2'd3);

    // R4
    idle_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_w && idle_w) |=> (code == POL_NONE));

endmodule

// File: rtl/vtd_hmeas.sv
// Horizontal timing measurement.
// A single segment counter restarts on every HSYNC or DE edge. The length of
// each segment is stored according to the event that closes it and the event
// that opened it.
// Assumes: hs and de are normalised (high while asserted). Only one event per
// clock; if several coincide, the first in priority order wins.
module vtd_hmeas #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs,
    input  logic          de,
    output logic [HW-1:0] hsw,
    output logic [HW-1:0] hbp,
    output logic [HW-1:0] wid,
    output logic [HW-1:0] hfp
);
    typedef enum logic [1:0] {EV_HR, EV_HF, EV_DR, EV_DF} hev_e;

    logic          hs_q, de_q;
    logic [HW-1:0] seg;
    hev_e          last_ev;
    logic          hr, hf, dr, df;

    assign hr = hs & ~hs_q;
    assign hf = ~hs & hs_q;
    assign dr = de & ~de_q;
    assign df = ~de & de_q;

    // Segment timing and capture per closing event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q    <= 1'b0;
            de_q    <= 1'b0;
            seg     <= '0;
            last_ev <= EV_DF;
            hsw     <= '0;
            hbp     <= '0;
            wid     <= '0;
            hfp     <= '0;
        end else begin
            hs_q <= hs;
            de_q <= de;
            if (hr || hf || dr || df) seg <= HW'(1);
            else if (seg != '1)       seg <= seg + HW'(1);
            if (hr) begin
                if (last_ev == EV_DF) hfp <= seg;
                last_ev <= EV_HR;
            end else if (hf) begin
                if (last_ev == EV_HR) hsw <= seg;
                last_ev <= EV_HF;
            end else if (dr) begin
                if (last_ev == EV_HF) hbp <= seg;
                last_ev <= EV_DR;
            end else if (df) begin
                if (last_ev == EV_DR) wid <= seg;
                last_ev <= EV_DF;
            end
        end
    end

endmodule

// File: rtl/vtd_vmeas.sv
// Vertical timing measurement.
// Counts lines (HSYNC assertions) for the VSYNC width, the back porch and the
// front porch, and counts active lines (DE rising edges) for the height.
// Exposes the frame edge (VSYNC assertion) and the live counters that the top
// publishes on that edge.
// Assumes normalised hs, vs and de inputs.
module vtd_vmeas #(
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs,
    input  logic          vs,
    input  logic          de,
    output logic          frame_edge,
    output logic [VW-1:0] vsw,
    output logic [VW-1:0] vbp,
    output logic [VW-1:0] fp_lc,
    output logic [VW-1:0] hgt
);
    logic          hs_q, vs_q, de_q;
    logic          hr, vr, vf, dr, df;
    logic          bp_pend;
    logic [VW-1:0] vs_lc, bp_lc;

    assign hr = hs & ~hs_q;
    assign vr = vs & ~vs_q;
    assign vf = ~vs & vs_q;
    assign dr = de & ~de_q;
    assign df = ~de & de_q;
    assign frame_edge = vr;

    // Line counters for sync width, back porch, front porch and height
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q    <= 1'b0;
            vs_q    <= 1'b0;
            de_q    <= 1'b0;
            bp_pend <= 1'b0;
            vs_lc   <= '0;
            bp_lc   <= '0;
            fp_lc   <= '0;
            hgt     <= '0;
            vsw     <= '0;
            vbp     <= '0;
        end else begin
            hs_q <= hs;
            vs_q <= vs;
            de_q <= de;
            if (vr)                       vs_lc <= hr ? VW'(1) : '0;
            else if (hr && vs_lc != '1)   vs_lc <= vs_lc + VW'(1);
            if (vf) vsw <= vs_lc;
            if (vf)                       bp_lc <= '0;
            else if (hr && bp_lc != '1)   bp_lc <= bp_lc + VW'(1);
            if (vf) begin
                bp_pend <= 1'b1;
            end else if (dr && bp_pend) begin
                vbp     <= bp_lc;
                bp_pend <= 1'b0;
            end
            if (df)                       fp_lc <= '0;
            else if (hr && fp_lc != '1)   fp_lc <= fp_lc + VW'(1);
            if (vr)                       hgt <= '0;
            else if (dr && hgt != '1)     hgt <= hgt + VW'(1);
        end
    end

endmodule

// File: rtl/vid_timing_detect.sv
// Video input timing detector, top level.
// Registers the raw inputs and classifies both syncs. Detects DE activity and
// runs the horizontal and vertical measurement units. The results are
// published once per frame, at the VSYNC assertion, after one complete frame
// with the stream present, and are cleared while no stream is present.
// Assumes all inputs are synchronous to clk (the pixel clock).
module vid_timing_detect
    import vtd_pkg::*;
#(
    parameter int HW  = 12,
    parameter int VW  = 11,
    parameter int TMO = 1 << 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync_in,
    input  logic          vsync_in,
    input  logic          de_in,
    input  logic          lock_in,
    input  logic          pclk_ok_in,
    output logic          link_up,
    output logic          stream_up,
    output logic [1:0]    hs_pol,
    output logic [1:0]    vs_pol,
    output logic [HW-1:0] act_width,
    output logic [VW-1:0] act_height,
    output logic [HW-1:0] hs_width,
    output logic [HW-1:0] hs_bporch,
    output logic [HW-1:0] hs_fporch,
    output logic [VW-1:0] vs_lines,
    output logic [VW-1:0] vs_bporch,
    output logic [VW-1:0] vs_fporch
);
    localparam int NSYNC = 2;
    localparam int IW = $clog2(TMO + 1);
    localparam logic [IW-1:0] TMO_V = IW'(TMO);

    logic              hs_r, vs_r, de_r, lk_r, ck_r;
    logic              de_q, de_seen;
    logic [IW-1:0]     de_idle;
    logic              de_live;
    logic [NSYNC-1:0]  raw_v, act_v;
    pol_e              code_v [NSYNC];
    logic [HW-1:0]     m_hsw, m_hbp, m_wid, m_hfp;
    logic [VW-1:0]     m_vsw, m_vbp, m_vfp, m_hgt;
    logic              frame_edge, armed;

    // Input sampling into the pixel-clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_r <= 1'b0;
            vs_r <= 1'b0;
            de_r <= 1'b0;
            lk_r <= 1'b0;
            ck_r <= 1'b0;
        end else begin
            hs_r <= hsync_in;
            vs_r <= vsync_in;
            de_r <= de_in;
            lk_r <= lock_in;
            ck_r <= pclk_ok_in;
        end
    end

    // DE activity: an edge within the last TMO clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_q    <= 1'b0;
            de_seen <= 1'b0;
            de_idle <= '0;
        end else begin
            de_q <= de_r;
            if (de_r ^ de_q) begin
                de_idle <= '0;
                de_seen <= 1'b1;
            end else if (de_idle < TMO_V) begin
                de_idle <= de_idle + IW'(1);
            end
        end
    end

    assign de_live   = de_seen && (de_idle < TMO_V);
    assign link_up   = lk_r;
    assign stream_up = lk_r & ck_r & de_live;

    assign raw_v = {vs_r, hs_r};

    // One polarity classifier per sync line (0: HSYNC, 1: VSYNC)
    for (genvar g = 0; g < NSYNC; g++) begin : g_cls
        vtd_sync_class #(.TMO(TMO)) u_cls (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_v[g]),
            .code  (code_v[g]),
            .act   (act_v[g])
        );
    end

    assign hs_pol = code_v[0];
    assign vs_pol = code_v[1];

    vtd_hmeas #(.HW(HW)) u_h (
        .clk   (clk),
        .rst_n (rst_n),
        .hs    (act_v[0]),
        .de    (de_r),
        .hsw   (m_hsw),
        .hbp   (m_hbp),
        .wid   (m_wid),
        .hfp   (m_hfp)
    );

    vtd_vmeas #(.VW(VW)) u_v (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs         (act_v[0]),
        .vs         (act_v[1]),
        .de         (de_r),
        .frame_edge (frame_edge),
        .vsw        (m_vsw),
        .vbp        (m_vbp),
        .fp_lc      (m_vfp),
        .hgt        (m_hgt)
    );

    // Per-frame publication of results; cleared while the stream is absent
    always_ff @(posedge clk) begin
        if (!rst_n || !stream_up) begin
            armed      <= 1'b0;
            act_width  <= '0;
            act_height <= '0;
            hs_width   <= '0;
            hs_bporch  <= '0;
            hs_fporch  <= '0;
            vs_lines   <= '0;
            vs_bporch  <= '0;
            vs_fporch  <= '0;
        end else if (frame_edge) begin
            armed <= 1'b1;
            if (armed) begin
                act_width  <= m_wid;
                act_height <= m_hgt;
                hs_width   <= m_hsw;
                hs_bporch  <= m_hbp;
                hs_fporch  <= m_hfp;
                vs_lines   <= m_vsw;
                vs_bporch  <= m_vbp;
                vs_fporch  <= m_vfp;
            end
        end
    end

    // R1
    link_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |-> !stream_up);

    // R2
    clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ck_r) |-> !stream_up);

    // R9
    clear_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_up |=> (act_width == '0 && act_height == '0 && vs_lines == '0
                        && hs_fporch == '0));

    // R8
    hold_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_up && !frame_edge) |=> ($stable(act_width) && $stable(act_height)
                                        && $stable(hs_bporch) && $stable(vs_bporch)));

    // R8
    unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_up && !armed) |=> (act_width == '0));

endmodule

// File: tb/sim_vid_timing_detect.sv
module sim_vid_timing_detect;
    localparam int HW  = 12;
    localparam int VW  = 11;
    localparam int TMO = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync_in = 1'b0, vsync_in = 1'b0, de_in = 1'b0;
    logic lock_in = 1'b0, pclk_ok_in = 1'b1;
    logic link_up, stream_up;
    logic [1:0] hs_pol, vs_pol;
    logic [HW-1:0] act_width, hs_width, hs_bporch, hs_fporch;
    logic [VW-1:0] act_height, vs_lines, vs_bporch, vs_fporch;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    int t_hsw, t_hbp, t_w, t_hfp, t_vsw, t_vbp, t_h, t_vfp;
    int line_len, nlines;
    logic hlow = 1'b0, vlow = 1'b0, de_kill = 1'b0, hs_kill = 1'b0;

    always #2.5 clk = ~clk;

    vid_timing_detect #(.HW(HW), .VW(VW), .TMO(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .de_in(de_in), .lock_in(lock_in), .pclk_ok_in(pclk_ok_in),
        .link_up(link_up), .stream_up(stream_up), .hs_pol(hs_pol), .vs_pol(vs_pol),
        .act_width(act_width), .act_height(act_height), .hs_width(hs_width),
        .hs_bporch(hs_bporch), .hs_fporch(hs_fporch), .vs_lines(vs_lines),
        .vs_bporch(vs_bporch), .vs_fporch(vs_fporch)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_timing(input int ts);
        if (ts == 0) begin
            t_hsw = 4; t_hbp = 6; t_w = 16; t_hfp = 5;
            t_vsw = 2; t_vbp = 3; t_h = 8;  t_vfp = 2;
        end else begin
            t_hsw = 3; t_hbp = 2; t_w = 20; t_hfp = 7;
            t_vsw = 1; t_vbp = 2; t_h = 6;  t_vfp = 3;
        end
        line_len = t_hsw + t_hbp + t_w + t_hfp;
        nlines   = t_vsw + t_vbp + t_h + t_vfp;
    endtask

    // Drives lines first..last of a frame, one pixel per clock, at negedges
    task automatic drive_lines(input int first, input int last);
        for (int l = first; l <= last; l++) begin
            for (int p = 0; p < line_len; p++) begin
                logic ha, va, da;
                ha = (p < t_hsw);
                va = (l < t_vsw);
                da = (l >= t_vsw + t_vbp) && (l < t_vsw + t_vbp + t_h) &&
                     (p >= t_hsw + t_hbp) && (p < t_hsw + t_hbp + t_w);
                hsync_in = hs_kill ? hlow : (ha ^ hlow);
                vsync_in = va ^ vlow;
                de_in    = da & ~de_kill;
                @(negedge clk);
            end
        end
    endtask

    task automatic drive_frames(input int n);
        for (int f = 0; f < n; f++) drive_lines(0, nlines - 1);
    endtask

    task automatic check_meas(input string tag);
        chk({"R5 hs_width ", tag},  int'(hs_width),  t_hsw);
        chk({"R5 hs_bporch ", tag}, int'(hs_bporch), t_hbp);
        chk({"R5 hs_fporch ", tag}, int'(hs_fporch), t_hfp);
        chk({"R6 act_width ", tag}, int'(act_width), t_w);
        chk({"R6 act_height ", tag}, int'(act_height), t_h);
        chk({"R7 vs_lines ", tag},  int'(vs_lines),  t_vsw);
        chk({"R7 vs_bporch ", tag}, int'(vs_bporch), t_vbp);
        chk({"R7 vs_fporch ", tag}, int'(vs_fporch), t_vfp);
    endtask

    task automatic check_zero(input string tag);
        chk({"R9 act_width zero ", tag},  int'(act_width),  0);
        chk({"R9 act_height zero ", tag}, int'(act_height), 0);
        chk({"R9 hs_width zero ", tag},   int'(hs_width),   0);
        chk({"R9 vs_fporch zero ", tag},  int'(vs_fporch),  0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        set_timing(0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R1 link_up after reset", int'(link_up), 0);
        chk("R2 stream_up after reset", int'(stream_up), 0);
        chk("R3 hs_pol after reset", int'(hs_pol), 2);
        chk("R3 vs_pol after reset", int'(vs_pol), 2);
        check_zero("after reset");

        // Sweep: timing set x HSYNC polarity x VSYNC polarity
        for (int cfg = 0; cfg < 8; cfg++) begin
            string tg;
            tg = $sformatf("cfg%0d", cfg);
            set_timing(cfg >> 2);
            hlow = cfg[0];
            vlow = cfg[1];
            lock_in = 1'b0;
            drive_frames(3);
            chk({"R1 link down ", tg}, int'(link_up), 0);
            chk({"R2 stream down without lock ", tg}, int'(stream_up), 0);
            check_zero({"lock low ", tg});
            // R3: the shorter phase is the asserted level
            chk({"R3 hs_pol ", tg}, int'(hs_pol), hlow ? 0 : 1);
            chk({"R3 vs_pol ", tg}, int'(vs_pol), vlow ? 0 : 1);
            // Lock rises partway through frame A
            drive_lines(0, 4);
            lock_in = 1'b1;
            drive_lines(5, nlines - 1);
            chk({"R1 link up ", tg}, int'(link_up), 1);
            chk({"R2 stream up ", tg}, int'(stream_up), 1);
            chk({"R8 zero before full frame A ", tg}, int'(act_width), 0);
            drive_frames(1);
            chk({"R8 zero after frame B ", tg}, int'(act_width), 0);
            chk({"R8 zero height after frame B ", tg}, int'(act_height), 0);
            drive_lines(0, 5);
            check_meas({"early ", tg});
            drive_lines(6, nlines - 1);
            check_meas({"late R8 ", tg});
        end

        // Pixel clock indication lost while the link stays locked
        pclk_ok_in = 1'b0;
        drive_lines(0, 1);
        chk("R2 stream down without pclk", int'(stream_up), 0);
        chk("R1 link stays up without pclk", int'(link_up), 1);
        check_zero("pclk lost R9");
        pclk_ok_in = 1'b1;
        drive_lines(2, nlines - 1);
        drive_frames(2);
        drive_lines(0, 3);
        chk("R2 stream recovers", int'(stream_up), 1);
        chk("R6 width after recovery", int'(act_width), t_w);
        drive_lines(4, nlines - 1);

        // DE stops toggling: locked link with no stream
        de_kill = 1'b1;
        drive_frames(3);
        chk("R2 stream down with static DE", int'(stream_up), 0);
        chk("R1 link up with static DE", int'(link_up), 1);
        check_zero("static DE R9");
        de_kill = 1'b0;

        // HSYNC held static: absent code, VSYNC unaffected
        hs_kill = 1'b1;
        drive_frames(3);
        chk("R4 hs_pol absent", int'(hs_pol), 2);
        chk("R4 vs_pol still classified", int'(vs_pol), vlow ? 0 : 1);
        hs_kill = 1'b0;

        finish_run();
    end
endmodule